// File: doc/BRIEF.md
# Accumulator ALU with status word

This block is the arithmetic core of a small 8-bit datapath. It holds an accumulator and a second operand register, and it runs one operation per clock when an operation is presented on a simple opcode input with an operand bus. The supported operations are load-accumulator, load-second-register, add, add with carry, subtract with borrow, an 8x8 unsigned multiply and an 8-by-8 unsigned divide. Each arithmetic operation updates the carry, auxiliary-carry and overflow flags under its own rules. A parity flag follows the accumulator at all times.

The flags sit in a status word. The same word holds two flags that belong to software and a two-bit selector for the working-register bank. Software reaches the status word through a register-bus port at one fixed address, and can both write it and read it back. The block turns the bank selector into the base address of the selected eight-byte register window, so that a neighbouring register file can use it.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, the second register and the status word are all 0x00, and the bank base is 0x00.
- R2: Opcode 3 (add) loads the accumulator with A+src, and opcode 4 (add with carry) loads it with A+src+carry, both modulo 256. Carry is set when the sum carries out of bit 7. Auxiliary carry is set when the low nibbles carry out of bit 3.
- R3: For opcodes 3, 4 and 5, overflow is set exactly when the signed (two's complement) result falls outside -128..127, and is cleared otherwise.
- R4: Opcode 5 (subtract with borrow) loads the accumulator with A-src-carry modulo 256. Carry is set when a borrow is needed. Auxiliary carry is set when the low nibble needs a borrow.
- R5: Opcode 6 (multiply) puts the low byte of A*B in the accumulator and the high byte in the second register. It sets overflow when the product exceeds 255 and clears carry and auxiliary carry.
- R6: Opcode 7 (divide) with a non-zero second register puts A/B in the accumulator and A mod B in the second register. It clears overflow, carry and auxiliary carry.
- R7: Opcode 7 with the second register at zero leaves both registers unchanged. It sets overflow and clears carry and auxiliary carry.
- R8: Status bit 0 is 1 exactly when the accumulator holds an odd number of ones. A bus write to bit 0 has no effect on it.
- R9: The status word layout, from bit 7 to bit 0, is carry, auxiliary carry, user flag 0, bank-select high, bank-select low, overflow, user flag 1, parity. A bus write at address 0xD0 loads bits 7..1. The bus reads back the status word at 0xD0 and reads 0x00 at any other address. A write to any other address has no effect.
- R10: The bank base output equals bank-select (bits 4:3) times 8, that is 0x00, 0x08, 0x10 or 0x18.
- R11: When a status write and an arithmetic opcode (3 to 7) fall in the same cycle, carry, auxiliary carry and overflow take the arithmetic result. User flag 0, user flag 1 and bank select take the bus value.
- R12: Opcode 0 (no operation), opcode 1 (load accumulator from src), opcode 2 (load second register from src), and any cycle with op_valid low leave carry, auxiliary carry and overflow unchanged. Opcodes 1 and 2 load their register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (0 nop, 1 load A, 2 load B, 3 add, 4 add with carry, 5 subtract with borrow, 6 multiply, 7 divide) |
| op_src | input | 8 | Source operand for loads, add and subtract |
| bus_addr | input | 8 | Register-bus address |
| bus_we | input | 1 | Register-bus write strobe |
| bus_wdata | input | 8 | Register-bus write data |
| bus_rdata | output | 8 | Register-bus read data, combinational from bus_addr |
| acc_q | output | 8 | Accumulator |
| breg_q | output | 8 | Second operand register |
| status_q | output | 8 | Status word |
| bank_base | output | 8 | Base address of the selected register bank |

## Verification
An operation or a status write is taken at one rising edge. The accumulator, the second register, the status word and the bank base all show the result right after that same edge. Parity follows the accumulator without any added delay, and bus_rdata follows bus_addr combinationally. The bench drives each stimulus at a falling edge and removes it at the next falling edge, after exactly one rising edge has passed. It then points bus_addr at the status word and compares every output against its own model a moment later. No result is ever sampled at an edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDA  = 3'd1,
    OP_LDB  = 3'd2,
    OP_ADD  = 3'd3,
    OP_ADDC = 3'd4,
    OP_SUBB = 3'd5,
    OP_MUL  = 3'd6,
    OP_DIV  = 3'd7
  } alu_op_e;

  // status word bit positions (decoded by the bank logic and software)
  localparam int ST_CY  = 7;
  localparam int ST_AC  = 6;
  localparam int ST_F0  = 5;
  localparam int ST_RSH = 4;
  localparam int ST_RSL = 3;
  localparam int ST_OV  = 2;
  localparam int ST_F1  = 1;
  localparam int ST_P   = 0;
  localparam int ST_W   = 8;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB) ||
           (op == OP_MUL) || (op == OP_DIV);
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          op_valid,
  input  alu_op_e       op,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] src,
  input  logic          cy_in,
  output logic [DW-1:0] a_nxt,
  output logic [DW-1:0] b_nxt,
  output logic          a_we,
  output logic          b_we,
  output logic          flag_we,
  output alu_flags_t    flags
);

  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          cy;
    logic          ac;
    logic          ov;
  } sum_t;

  function automatic sum_t do_add(logic [DW-1:0] x, logic [DW-1:0] y, logic c);
    sum_t          r;
    logic [DW:0]   full;
    logic [HW:0]   half;
    full  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
    half  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, c};
    r.res = full[DW-1:0];
    r.cy  = full[DW];
    r.ac  = half[HW];
    r.ov  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    return r;
  endfunction

  function automatic sum_t do_sub(logic [DW-1:0] x, logic [DW-1:0] y, logic c);
    sum_t          r;
    logic [DW:0]   full;
    logic [HW:0]   half;
    full  = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, c};
    half  = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, c};
    r.res = full[DW-1:0];
    r.cy  = full[DW];
    r.ac  = half[HW];
    r.ov  = (x[MSB] != y[MSB]) && (full[MSB] != x[MSB]);
    return r;
  endfunction

  function automatic logic [2*DW-1:0] do_mul(logic [DW-1:0] x, logic [DW-1:0] y);
    return {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
  endfunction

  sum_t            add_r;
  sum_t            sub_r;
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   quot;
  logic [DW-1:0]   rem;
  logic            div_zero;

  always_comb begin
    add_r    = do_add(a_in, src, (op == OP_ADDC) ? cy_in : 1'b0);
    sub_r    = do_sub(a_in, src, cy_in);
    prod     = do_mul(a_in, b_in);
    div_zero = (b_in == '0);
    quot     = div_zero ? '0 : (a_in / b_in);
    rem      = div_zero ? '0 : (a_in % b_in);
  end

  always_comb begin
    a_nxt   = a_in;
    b_nxt   = b_in;
    a_we    = 1'b0;
    b_we    = 1'b0;
    flag_we = 1'b0;
    flags   = '0;
    if (op_valid) begin
      unique case (op)
        OP_NOP: ;
        OP_LDA: begin
          a_nxt = src;
          a_we  = 1'b1;
        end
        OP_LDB: begin
          b_nxt = src;
          b_we  = 1'b1;
        end
        OP_ADD, OP_ADDC: begin
          a_nxt   = add_r.res;
          a_we    = 1'b1;
          flag_we = 1'b1;
          flags   = '{cy: add_r.cy, ac: add_r.ac, ov: add_r.ov};
        end
        OP_SUBB: begin
          a_nxt   = sub_r.res;
          a_we    = 1'b1;
          flag_we = 1'b1;
          flags   = '{cy: sub_r.cy, ac: sub_r.ac, ov: sub_r.ov};
        end
        OP_MUL: begin
          a_nxt   = prod[DW-1:0];
          b_nxt   = prod[2*DW-1:DW];
          a_we    = 1'b1;
          b_we    = 1'b1;
          flag_we = 1'b1;
          flags   = '{cy: 1'b0, ac: 1'b0, ov: |prod[2*DW-1:DW]};
        end
        OP_DIV: begin
          a_nxt   = quot;
          b_nxt   = rem;
          a_we    = !div_zero;
          b_we    = !div_zero;
          flag_we = 1'b1;
          flags   = '{cy: 1'b0, ac: 1'b0, ov: div_zero};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
  import acc_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_we,
  input  alu_flags_t      flags,
  input  logic            wr_hit,
  input  logic [ST_W-1:1] wr_bits,
  input  logic            parity,
  output logic [ST_W-1:0] status
);

  logic            cy_q, ac_q, ov_q, f0_q, f1_q;
  logic [1:0]      rs_q;
  logic            cy_d, ac_d, ov_d, f0_d, f1_d;
  logic [1:0]      rs_d;

  always_comb begin
    cy_d = cy_q;
    ac_d = ac_q;
    ov_d = ov_q;
    f0_d = f0_q;
    f1_d = f1_q;
    rs_d = rs_q;
    if (wr_hit) begin
      cy_d = wr_bits[ST_CY];
      ac_d = wr_bits[ST_AC];
      ov_d = wr_bits[ST_OV];
      f0_d = wr_bits[ST_F0];
      f1_d = wr_bits[ST_F1];
      rs_d = wr_bits[ST_RSH:ST_RSL];
    end
    // arithmetic result overrides the bus for its own flags
    if (flag_we) begin
      cy_d = flags.cy;
      ac_d = flags.ac;
      ov_d = flags.ov;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      ac_q <= 1'b0;
      ov_q <= 1'b0;
      f0_q <= 1'b0;
      f1_q <= 1'b0;
      rs_q <= 2'b00;
    end else begin
      cy_q <= cy_d;
      ac_q <= ac_d;
      ov_q <= ov_d;
      f0_q <= f0_d;
      f1_q <= f1_d;
      rs_q <= rs_d;
    end
  end

  always_comb begin
    status                 = '0;
    status[ST_CY]          = cy_q;
    status[ST_AC]          = ac_q;
    status[ST_F0]          = f0_q;
    status[ST_RSH:ST_RSL]  = rs_q;
    status[ST_OV]          = ov_q;
    status[ST_F1]          = f1_q;
    status[ST_P]           = parity;
  end

endmodule

// File: rtl/acc_alu_bank.sv
module acc_alu_bank #(
  parameter int ADDR_W     = 8,
  parameter int BANK_BYTES = 8,
  parameter int SEL_W      = 2
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] base
);

  localparam int SHIFT = $clog2(BANK_BYTES);

  generate
    if (SHIFT == 0) begin : g_noshift
      assign base = ADDR_W'(sel);
    end else begin : g_shift
      assign base = ADDR_W'({sel, {SHIFT{1'b0}}});
    end
  endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int              DW          = 8,
  parameter int              ADDR_W      = 8,
  parameter int              BANK_BYTES  = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DW-1:0]     op_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [ST_W-1:0]   bus_wdata,
  output logic [ST_W-1:0]   bus_rdata,
  output logic [DW-1:0]     acc_q,
  output logic [DW-1:0]     breg_q,
  output logic [ST_W-1:0]   status_q,
  output logic [ADDR_W-1:0] bank_base
);

  localparam int SEL_W = ST_RSH - ST_RSL + 1;

  alu_op_e       op;
  logic [DW-1:0] a_nxt, b_nxt;
  logic          a_we, b_we;
  logic          flag_we;
  alu_flags_t    flags;
  logic          addr_hit;
  logic          wr_hit;
  logic          parity;
  logic          wdata_unused;

  assign op           = alu_op_e'(op_code);
  assign addr_hit     = (bus_addr == STATUS_ADDR);
  assign wr_hit       = bus_we && addr_hit;
  assign parity       = ^acc_q;
  assign wdata_unused = bus_wdata[ST_P];

  acc_alu_arith #(.DW(DW)) u_arith (
    .op_valid (op_valid),
    .op       (op),
    .a_in     (acc_q),
    .b_in     (breg_q),
    .src      (op_src),
    .cy_in    (status_q[ST_CY]),
    .a_nxt    (a_nxt),
    .b_nxt    (b_nxt),
    .a_we     (a_we),
    .b_we     (b_we),
    .flag_we  (flag_we),
    .flags    (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      breg_q <= '0;
    end else begin
      if (a_we) acc_q  <= a_nxt;
      if (b_we) breg_q <= b_nxt;
    end
  end

  acc_alu_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_we (flag_we),
    .flags   (flags),
    .wr_hit  (wr_hit),
    .wr_bits (bus_wdata[ST_W-1:1]),
    .parity  (parity),
    .status  (status_q)
  );

  acc_alu_bank #(
    .ADDR_W     (ADDR_W),
    .BANK_BYTES (BANK_BYTES),
    .SEL_W      (SEL_W)
  ) u_bank (
    .sel  (status_q[ST_RSH:ST_RSL]),
    .base (bank_base)
  );

  assign bus_rdata = addr_hit ? status_q : '0;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ADDR_W     = 8,
  parameter int BANK_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              flag_we,
  input logic              wr_hit,
  input logic [ST_W-1:0]   bus_wdata,
  input logic [DW-1:0]     acc_q,
  input logic [DW-1:0]     breg_q,
  input logic [ST_W-1:0]   status_q,
  input logic [ADDR_W-1:0] bank_base
);

  logic mul_ev, div_ev, quiet_ev;
  assign mul_ev   = op_valid && (op_code == OP_MUL);
  assign div_ev   = op_valid && (op_code == OP_DIV);
  assign quiet_ev = !wr_hit && (!op_valid || (op_code == OP_NOP) ||
                    (op_code == OP_LDA) || (op_code == OP_LDB));

  AST_PARITY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_P] == ^acc_q); // R8

  AST_BANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bank_base == ADDR_W'(32'(status_q[ST_RSH:ST_RSL]) * BANK_BYTES)); // R10

  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mul_ev |=> !status_q[ST_CY] && !status_q[ST_AC] &&
               (status_q[ST_OV] == (breg_q != '0))); // R5

  AST_DIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ev && breg_q != '0) |=> !status_q[ST_OV] && !status_q[ST_CY]); // R6

  AST_DIV_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ev && breg_q == '0) |=> status_q[ST_OV] && $stable(acc_q) &&
                                 $stable(breg_q)); // R7

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_ev |=> $stable(status_q[ST_W-1:1])); // R12

  AST_BUS_USER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && wr_hit) |=> (status_q[ST_F0] == $past(bus_wdata[ST_F0])) &&
                            (status_q[ST_F1] == $past(bus_wdata[ST_F1])) &&
                            (status_q[ST_RSH:ST_RSL] == $past(bus_wdata[ST_RSH:ST_RSL]))); // R11

endmodule

bind acc_alu acc_alu_chk #(
  .DW         (DW),
  .ADDR_W     (ADDR_W),
  .BANK_BYTES (BANK_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .flag_we   (flag_we),
  .wr_hit    (wr_hit),
  .bus_wdata (bus_wdata),
  .acc_q     (acc_q),
  .breg_q    (breg_q),
  .status_q  (status_q),
  .bank_base (bank_base)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  localparam int CLK_P = 10;
  localparam int STAT  = 'hD0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] op_src = '0;
  logic [7:0] bus_addr = STAT[7:0];
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, acc_q, breg_q, status_q, bank_base;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  int m_acc = 0, m_b = 0;
  bit m_cy = 0, m_ac = 0, m_ov = 0, m_f0 = 0, m_f1 = 0;
  int m_rs = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_src(op_src), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .acc_q(acc_q),
    .breg_q(breg_q), .status_q(status_q), .bank_base(bank_base)
  );

  function automatic int sgn8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int ones(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int exp_status();
    return (int'(m_cy) << 7) | (int'(m_ac) << 6) | (int'(m_f0) << 5) |
           (m_rs << 3) | (int'(m_ov) << 2) | (int'(m_f1) << 1) |
           (ones(m_acc) % 2);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // model of one cycle: arithmetic uses the flags from before the cycle
  task automatic model(bit v, int op, int src, bit we, int addr, int wd);
    bit arith = v && (op >= 3);
    if (v) begin
      case (op)
        1: m_acc = src;
        2: m_b = src;
        3, 4: begin
          int cin = (op == 4) ? int'(m_cy) : 0;
          int u = m_acc + src + cin;
          int s = sgn8(m_acc) + sgn8(src) + cin;
          m_cy = u > 255;
          m_ac = ((m_acc % 16) + (src % 16) + cin) > 15;
          m_ov = (s > 127) || (s < -128);
          m_acc = u % 256;
        end
        5: begin
          int cin = int'(m_cy);
          int u = m_acc - src - cin;
          int s = sgn8(m_acc) - sgn8(src) - cin;
          m_cy = u < 0;
          m_ac = ((m_acc % 16) - (src % 16) - cin) < 0;
          m_ov = (s > 127) || (s < -128);
          m_acc = (u + 256) % 256;
        end
        6: begin
          int p = m_acc * m_b;
          m_cy = 0; m_ac = 0; m_ov = p > 255;
          m_acc = p % 256; m_b = p / 256;
        end
        7: begin
          m_cy = 0; m_ac = 0;
          if (m_b == 0) m_ov = 1;
          else begin
            int q = m_acc / m_b;
            m_ov = 0; m_b = m_acc % m_b; m_acc = q;
          end
        end
        default: ;
      endcase
    end
    if (we && addr == STAT) begin
      m_f0 = wd[5]; m_f1 = wd[1]; m_rs = (wd >> 3) & 3;
      if (!arith) begin m_cy = wd[7]; m_ac = wd[6]; m_ov = wd[2]; end
    end
  endtask

  task automatic step(string tag, bit v, int op, int src, bit we, int addr, int wd);
    op_valid  = v;
    op_code   = op[2:0];
    op_src    = src[7:0];
    bus_we    = we;
    bus_addr  = addr[7:0];
    bus_wdata = wd[7:0];
    model(v, op, src, we, addr, wd);
    @(negedge clk);
    op_valid = 1'b0;
    bus_we   = 1'b0;
    bus_addr = STAT[7:0];
    #1;
    chk(tag, "acc", int'(acc_q), m_acc);
    chk(tag, "breg", int'(breg_q), m_b);
    chk(tag, "status", int'(status_q), exp_status());
    chk(tag, "rdata", int'(bus_rdata), exp_status());
    chk("R10", "bank_base", int'(bank_base), m_rs * 8);
  endtask

  task automatic op1(string tag, int op, int src);
    step(tag, 1'b1, op, src, 1'b0, STAT, 0);
  endtask

  function automatic string tag_of(int op);
    case (op)
      3, 4: return "R2";
      5: return "R4";
      6: return "R5";
      7: return (m_b == 0) ? "R7" : "R6";
      default: return "R12";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "acc", int'(acc_q), 0);
    chk("R1", "breg", int'(breg_q), 0);
    chk("R1", "status", int'(status_q), 0);
    chk("R1", "bank_base", int'(bank_base), 0);

    // R2 / R3 add corners
    op1("R12", 1, 'h7F);
    op1("R3", 3, 'h01);                 // 0x80: OV, AC
    chk("R3", "ov", int'(status_q[2]), 1);
    op1("R12", 1, 'hFF);
    op1("R2", 3, 'h01);                 // 0x00 with CY, AC
    chk("R2", "cy", int'(status_q[7]), 1);
    op1("R2", 4, 'h10);                 // carry in: 0x11
    chk("R2", "acc_addc", int'(acc_q), 'h11);
    // R4 subtract corners
    op1("R12", 1, 'h00);
    op1("R4", 5, 'h01);                 // borrow: 0xFF
    chk("R4", "cy", int'(status_q[7]), 1);
    op1("R12", 1, 'h80);
    op1("R3", 5, 'h00);                 // 0x80-0-1 = 0x7F, OV
    chk("R3", "ov_sub", int'(status_q[2]), 1);
    // R5 multiply
    op1("R12", 1, 'h10); op1("R12", 2, 'h10);
    op1("R5", 6, 0);
    chk("R5", "ov_mul", int'(status_q[2]), 1);
    op1("R12", 1, 3); op1("R12", 2, 4);
    op1("R5", 6, 0);
    chk("R5", "ov_small", int'(status_q[2]), 0);
    // R6 / R7 divide
    op1("R12", 1, 200); op1("R12", 2, 7);
    op1("R6", 7, 0);
    op1("R12", 2, 0);
    op1("R7", 7, 0);
    chk("R7", "ov_div0", int'(status_q[2]), 1);
    // R8 / R9 bus write, parity bit ignored
    op1("R12", 1, 'h01);
    step("R8", 1'b0, 0, 0, 1'b1, STAT, 'hFE);
    step("R8", 1'b0, 0, 0, 1'b1, STAT, 'h01);
    chk("R8", "parity", int'(status_q[0]), 1);
    step("R9", 1'b0, 0, 0, 1'b1, 'h55, 'hFF);   // other address ignored
    bus_addr = 8'h55; #1;
    chk("R9", "rdata_other", int'(bus_rdata), 0);
    bus_addr = STAT[7:0];
    // R10 every bank
    for (int k = 0; k < 4; k++) step("R10", 1'b0, 0, 0, 1'b1, STAT, k << 3);
    // R11 collision: arithmetic wins for its flags
    step("R11", 1'b1, 3, 'hF0, 1'b1, STAT, 'hFF);
    chk("R11", "f0", int'(status_q[5]), 1);
    // R12 idle with arithmetic code
    step("R12", 1'b0, 3, 'h55, 1'b0, STAT, 0);

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 7);
      int src = $urandom_range(0, 255);
      bit v = ($urandom_range(0, 9) != 0);
      bit we = ($urandom_range(0, 5) == 0);
      int addr = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : STAT;
      int wd = $urandom_range(0, 255);
      if (op == 7 && $urandom_range(0, 3) == 0) op1("R12", 2, 0);
      step(v ? tag_of(op) : "R12", v, op, src, we, addr, wd);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule